// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of a dynamically scheduled floating-point pipeline. Decoded instructions arrive in program order, one at a time, each carrying an operation class, a destination register and two source registers. The controller owns five execution slots: one integer/load slot, two multiply slots, one add/subtract slot and one divide slot. It tracks every instruction in flight and moves each one through four phases: issue, operand read, execution and result write.

Each slot holds a status record. The record stores whether the slot is occupied, its operation, its destination and source register numbers, the slot that will produce each source, and a ready flag for each source. A per-register table names the slot that will next write each register. Issue is refused on a structural or write-after-write conflict. Operand read waits for true data dependences to resolve. Result write waits while an older reader still needs the previous value of the destination.

Execution is modelled by a fixed-latency timer per slot. The timer starts on the operand-read pulse and reports completion back to the controller. The operand-read pulses double as register-file read enables, and the single write grant per cycle drives the register-file write port.

Top module: `sb_scoreboard`

## Requirements
- R1: After a synchronous reset no slot is occupied, `fu_start` is all zero, `wb_en` is low, and `in_ready` is high for any operation class.
- R2: Class encoding on `in_op` is 0 load, 1 multiply, 2 add/subtract, 3 divide. Slot numbers on `iss_unit` and `wb_unit` are 0 integer, 1 first multiplier, 2 second multiplier, 3 adder, 4 divider. A multiply takes slot 1 when it is free, otherwise slot 2. `in_ready` is low when no slot of the class is free. A slot stays occupied from the cycle after its issue until the cycle after its write grant.
- R3: `in_ready` is low while any occupied slot has the same destination register as the presented instruction.
- R4: Instructions are accepted strictly in the order presented. A refused instruction is held, and nothing behind it is accepted until it issues.
- R5: `fu_start[u]` is high for exactly one cycle once both sources of slot u have no pending producer. This is at the earliest the cycle after issue. A load has no floating-point sources and reads in the cycle after issue.
- R6: A slot whose `fu_start` pulse occurs in cycle t is eligible for its write grant from cycle t+LAT+1, where LAT is that slot's latency parameter.
- R7: A finished slot is not granted the write port while another occupied non-load slot still has a ready, unread source register equal to the finished slot's destination.
- R8: At most one write is granted per cycle. Among eligible slots, the lowest slot number wins.
- R9: On a write, every slot waiting on the writing slot marks that source ready, and it may read from the next cycle. An instruction that issues in the same cycle as the write of one of its sources treats that source as ready.
- R10: Once a slot is granted its write, both the slot and its destination register may be used by an instruction issuing in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_op | input | 2 | Operation class of the presented instruction |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| in_ready | output | 1 | Presented instruction can issue this cycle |
| iss_unit | output | 3 | Slot the presented instruction would issue into |
| fu_start | output | 5 | Per-slot operand read and execution start pulse |
| wb_en | output | 1 | Register-file write enable |
| wb_reg | output | 5 | Register being written |
| wb_unit | output | 3 | Slot whose result is written |

## Verification
The hardest state to reach from the ports is a write-after-read stall. It needs a finished slot whose destination is still named as a ready but unread source of an older instruction, and that older instruction must itself be stuck waiting on a slow producer for its other source. The bench builds this directly with a long divide whose second source is later overwritten by a short add, while the divide's first source comes from a ten-cycle multiply. It then runs a long pseudo-random stream over only eight registers, so that true, output and anti dependences overlap constantly and several slots finish in the same cycle. A behavioural reference model is compared against every output on every clock.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NFU    = 5;
    localparam int UW     = 3;
    localparam int REGW   = 5;
    localparam int NREG   = 1 << REGW;

    localparam int U_INT  = 0;
    localparam int U_MUL1 = 1;
    localparam int U_MUL2 = 2;
    localparam int U_ADD  = 3;
    localparam int U_DIV  = 4;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_MUL  = 2'd1,
        OP_ADD  = 2'd2,
        OP_DIV  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPS  = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    // producer tags: 0 means "value already in the register file"
    typedef logic [UW-1:0] tag_t;

    typedef struct packed {
        logic            busy;
        st_e             st;
        op_e             op;
        logic [REGW-1:0] fi;
        logic [REGW-1:0] fj;
        logic [REGW-1:0] fk;
        tag_t            qj;
        tag_t            qk;
        logic            rj;
        logic            rk;
    } fu_ent_t;

    function automatic tag_t unit_tag(input logic [UW-1:0] u);
        return u + tag_t'(1);
    endfunction

    function automatic logic [UW-1:0] tag_unit(input tag_t t);
        return t - tag_t'(1);
    endfunction

endpackage

// File: rtl/sb_fu_timer.sv
module sb_fu_timer #(
    parameter int LAT = 1,
    parameter int CW  = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= LAT[CW-1:0];
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign done = (cnt == CW'(1));

    // R6: a running slot is never restarted before its count expires
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> !start);

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // fixed priority, lowest index first (R8)
    always_comb begin
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (grant == '0))
                grant[i] = 1'b1;
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [REGW-1:0] in_dst,
    input  logic [REGW-1:0] in_src1,
    input  logic [REGW-1:0] in_src2,
    output logic            in_ready,
    output logic [UW-1:0]   iss_unit,
    output logic [NFU-1:0]  fu_start,
    output logic            wb_en,
    output logic [REGW-1:0] wb_reg,
    output logic [UW-1:0]   wb_unit
);
    fu_ent_t        ent   [NFU];
    tag_t           rstat [NREG];

    logic [NFU-1:0] busy;
    logic [NFU-1:0] fu_done;
    logic [NFU-1:0] war;
    logic [NFU-1:0] wb_req;
    logic [NFU-1:0] wb_grant;
    logic [UW-1:0]  sel;
    logic           sel_ok;
    logic           waw;
    logic           do_issue;
    tag_t           wb_tag;
    fu_ent_t        new_ent;

    // ---------------- issue ----------------
    always_comb begin
        for (int u = 0; u < NFU; u++) busy[u] = ent[u].busy;
    end

    always_comb begin
        sel    = '0;
        sel_ok = 1'b0;
        case (op_e'(in_op))
            OP_LOAD: if (!busy[U_INT]) begin sel = UW'(U_INT); sel_ok = 1'b1; end
            OP_MUL: begin
                if (!busy[U_MUL1])      begin sel = UW'(U_MUL1); sel_ok = 1'b1; end
                else if (!busy[U_MUL2]) begin sel = UW'(U_MUL2); sel_ok = 1'b1; end
            end
            OP_ADD:  if (!busy[U_ADD]) begin sel = UW'(U_ADD); sel_ok = 1'b1; end
            default: if (!busy[U_DIV]) begin sel = UW'(U_DIV); sel_ok = 1'b1; end
        endcase
    end

    assign waw      = (rstat[in_dst] != '0);
    assign in_ready = sel_ok && !waw;
    assign iss_unit = sel;
    assign do_issue = in_valid && in_ready;

    // new status record; a source written this very cycle counts as ready
    always_comb begin
        new_ent      = '0;
        new_ent.busy = 1'b1;
        new_ent.st   = ST_OPS;
        new_ent.op   = op_e'(in_op);
        new_ent.fi   = in_dst;
        if (op_e'(in_op) == OP_LOAD) begin
            new_ent.rj = 1'b1;
            new_ent.rk = 1'b1;
        end else begin
            new_ent.fj = in_src1;
            new_ent.fk = in_src2;
            new_ent.qj = (wb_en && wb_reg == in_src1) ? '0 : rstat[in_src1];
            new_ent.qk = (wb_en && wb_reg == in_src2) ? '0 : rstat[in_src2];
            new_ent.rj = (new_ent.qj == '0);
            new_ent.rk = (new_ent.qk == '0);
        end
    end

    // ---------------- read operands / execute ----------------
    always_comb begin
        for (int u = 0; u < NFU; u++)
            fu_start[u] = (ent[u].st == ST_OPS) && ent[u].rj && ent[u].rk;
    end

    for (genvar u = 0; u < NFU; u++) begin : g_fu
        localparam int L = (u == U_INT) ? LAT_INT :
                           (u == U_ADD) ? LAT_ADD :
                           (u == U_DIV) ? LAT_DIV : LAT_MUL;

        sb_fu_timer #(.LAT(L)) u_tmr (
            .clk   (clk),
            .rst   (rst),
            .start (fu_start[u]),
            .done  (fu_done[u])
        );

        // R5: operand read is a single-cycle pulse
        a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
            fu_start[u] |=> !fu_start[u]);

        // R9: a slot waiting on a source names a producer that is still live
        a_r9_wait_on_live: assert property (@(posedge clk) disable iff (rst)
            (ent[u].st == ST_OPS && !ent[u].rj) |-> ent[tag_unit(ent[u].qj)].busy);
    end

    // ---------------- write result ----------------
    always_comb begin
        for (int u = 0; u < NFU; u++) begin
            war[u] = 1'b0;
            for (int v = 0; v < NFU; v++) begin
                if (v != u && ent[v].busy && ent[v].op != OP_LOAD &&
                    ((ent[v].rj && ent[v].fj == ent[u].fi) ||
                     (ent[v].rk && ent[v].fk == ent[u].fi)))
                    war[u] = 1'b1;
            end
            wb_req[u] = (ent[u].st == ST_DONE) && !war[u];
        end
    end

    sb_wb_arb #(.N(NFU)) u_arb (
        .req   (wb_req),
        .grant (wb_grant)
    );

    always_comb begin
        wb_unit = '0;
        for (int u = 0; u < NFU; u++)
            if (wb_grant[u]) wb_unit = UW'(u);
    end

    assign wb_en  = |wb_grant;
    assign wb_reg = ent[wb_unit].fi;
    assign wb_tag = unit_tag(wb_unit);

    // ---------------- state update ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int u = 0; u < NFU; u++)  ent[u]   <= '0;
            for (int r = 0; r < NREG; r++) rstat[r] <= '0;
        end else begin
            for (int u = 0; u < NFU; u++) begin
                if (fu_start[u]) begin
                    ent[u].st <= ST_EXEC;
                    ent[u].rj <= 1'b0;
                    ent[u].rk <= 1'b0;
                end
                if (fu_done[u])
                    ent[u].st <= ST_DONE;
                if (wb_grant[u]) begin
                    ent[u].busy <= 1'b0;
                    ent[u].st   <= ST_IDLE;
                end
                if (wb_en && ent[u].st == ST_OPS) begin
                    if (ent[u].qj == wb_tag) begin
                        ent[u].rj <= 1'b1;
                        ent[u].qj <= '0;
                    end
                    if (ent[u].qk == wb_tag) begin
                        ent[u].rk <= 1'b1;
                        ent[u].qk <= '0;
                    end
                end
            end
            if (wb_en)
                rstat[wb_reg] <= '0;
            if (do_issue) begin
                ent[sel]      <= new_ent;
                rstat[in_dst] <= unit_tag(sel);
            end
        end
    end

    // ---------------- assertions ----------------
    // R8: at most one write per cycle
    a_r8_one_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

    // R3: every pending destination belongs to a live slot writing that register
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        a_r3_owner_live: assert property (@(posedge clk) disable iff (rst)
            (rstat[r] != '0) |->
                (ent[tag_unit(rstat[r])].busy && ent[tag_unit(rstat[r])].fi == REGW'(r)));
    end

    // R7: no granted writer leaves a ready, unread reader of its destination
    for (genvar v = 0; v < NFU; v++) begin : g_war
        a_r7_no_stale_reader: assert property (@(posedge clk) disable iff (rst)
            (wb_en && wb_unit != UW'(v) && ent[v].busy && ent[v].op != OP_LOAD) |->
                !((ent[v].rj && ent[v].fj == wb_reg) || (ent[v].rk && ent[v].fk == wb_reg)));
    end

endmodule

// File: tb/sb_scoreboard_tb.sv
module sb_scoreboard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NU   = 5;
    localparam int NPRG = 180;
    localparam int WD_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [1:0] in_op;
    logic [4:0] in_dst, in_src1, in_src2;
    logic       in_ready;
    logic [2:0] iss_unit;
    logic [4:0] fu_start;
    logic       wb_en;
    logic [4:0] wb_reg;
    logic [2:0] wb_unit;

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_scoreboard u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ready(in_ready), .iss_unit(iss_unit), .fu_start(fu_start),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_unit(wb_unit)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // program
    int p_op [NPRG];
    int p_d  [NPRG];
    int p_a  [NPRG];
    int p_b  [NPRG];
    int pc = 0;
    int accepted = 0;

    // reference model state (tags: 0 none, else slot+1)
    int m_busy [NU];
    int m_st   [NU];   // 0 free, 1 waiting operands, 2 running, 3 finished
    int m_op   [NU];
    int m_fi   [NU];
    int m_fj   [NU];
    int m_fk   [NU];
    int m_qj   [NU];
    int m_qk   [NU];
    int m_rj   [NU];
    int m_rk   [NU];
    int m_left [NU];
    int m_fwd  [NU];
    int m_rs   [32];
    int freed_last = 0;

    // expected outputs
    int e_ready, e_sel, e_waw, e_wb, e_wunit, e_wreg, e_warblk, e_nreq;
    int e_start [NU];

    function automatic int lat_of(int u);
        if (u == 0) return 1;
        if (u == 3) return 2;
        if (u == 4) return 40;
        return 10;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < NU; u++) begin
            m_busy[u] = 0; m_st[u] = 0; m_op[u] = 0; m_fi[u] = 0; m_fj[u] = 0;
            m_fk[u] = 0; m_qj[u] = 0; m_qk[u] = 0; m_rj[u] = 0; m_rk[u] = 0;
            m_left[u] = 0; m_fwd[u] = 0;
        end
        for (int r = 0; r < 32; r++) m_rs[r] = 0;
        freed_last = 0;
    endtask

    // R2 R3 R5 R6 R7 R8: expected outputs from the model state and current inputs
    task automatic model_eval();
        int op;
        op = int'(in_op);
        e_sel = 0; e_ready = 0;
        if (op == 0)      begin if (!m_busy[0]) begin e_sel = 0; e_ready = 1; end end
        else if (op == 1) begin
            if (!m_busy[1])      begin e_sel = 1; e_ready = 1; end
            else if (!m_busy[2]) begin e_sel = 2; e_ready = 1; end
        end
        else if (op == 2) begin if (!m_busy[3]) begin e_sel = 3; e_ready = 1; end end
        else              begin if (!m_busy[4]) begin e_sel = 4; e_ready = 1; end end
        e_waw = (m_rs[in_dst] != 0);
        if (e_waw) e_ready = 0;

        for (int u = 0; u < NU; u++)
            e_start[u] = (m_st[u] == 1 && m_rj[u] && m_rk[u]) ? 1 : 0;

        e_wb = 0; e_wunit = 0; e_wreg = 0; e_warblk = 0; e_nreq = 0;
        for (int u = 0; u < NU; u++) begin
            if (m_st[u] == 3) begin
                bit blocked = 0;
                for (int v = 0; v < NU; v++)
                    if (v != u && m_busy[v] && m_op[v] != 0 &&
                        ((m_rj[v] && m_fj[v] == m_fi[u]) || (m_rk[v] && m_fk[v] == m_fi[u])))
                        blocked = 1;
                if (blocked) e_warblk = 1;
                else begin
                    e_nreq++;
                    if (!e_wb) begin e_wb = 1; e_wunit = u; e_wreg = m_fi[u]; end
                end
            end
        end
    endtask

    task automatic model_step();
        int nqj, nqk, issue;
        issue = (in_valid && e_ready);
        nqj = 0; nqk = 0;
        if (issue && in_op != 2'd0) begin
            nqj = (e_wb && e_wreg == int'(in_src1)) ? 0 : m_rs[in_src1];
            nqk = (e_wb && e_wreg == int'(in_src2)) ? 0 : m_rs[in_src2];
        end
        for (int u = 0; u < NU; u++) begin
            m_fwd[u] = 0;
            if (e_start[u]) begin
                m_st[u] = 2; m_rj[u] = 0; m_rk[u] = 0; m_left[u] = lat_of(u);
            end else if (m_st[u] == 2) begin
                m_left[u]--;
                if (m_left[u] == 0) m_st[u] = 3;
            end
        end
        freed_last = 0;
        if (e_wb) begin
            for (int u = 0; u < NU; u++)
                if (m_st[u] == 1) begin
                    if (m_qj[u] == e_wunit + 1) begin m_rj[u] = 1; m_qj[u] = 0; m_fwd[u] = 1; end
                    if (m_qk[u] == e_wunit + 1) begin m_rk[u] = 1; m_qk[u] = 0; m_fwd[u] = 1; end
                end
            m_busy[e_wunit] = 0; m_st[e_wunit] = 0;
            m_rs[e_wreg] = 0;
            freed_last = 1;
        end
        if (issue) begin
            int s;
            s = e_sel;
            m_busy[s] = 1; m_st[s] = 1; m_op[s] = int'(in_op); m_fi[s] = int'(in_dst);
            if (in_op == 2'd0) begin
                m_fj[s] = 0; m_fk[s] = 0; m_qj[s] = 0; m_qk[s] = 0; m_rj[s] = 1; m_rk[s] = 1;
            end else begin
                m_fj[s] = int'(in_src1); m_fk[s] = int'(in_src2);
                m_qj[s] = nqj; m_qk[s] = nqk;
                m_rj[s] = (nqj == 0); m_rk[s] = (nqk == 0);
            end
            m_rs[in_dst] = s + 1;
            pc++;
            accepted++;
        end
    endtask

    function automatic bit model_idle();
        for (int u = 0; u < NU; u++) if (m_busy[u]) return 0;
        return 1;
    endfunction

    task automatic put(input int i, input int op, input int d, input int a, input int b);
        p_op[i] = op; p_d[i] = d; p_a[i] = a; p_b[i] = b;
    endtask

    task automatic build_program();
        int unsigned seed;
        // dependence chain with a WAR stall (R7) and a RAW wait (R9)
        put(0, 0, 6, 0, 0);    // load F6
        put(1, 0, 2, 0, 0);    // load F2
        put(2, 1, 0, 2, 4);    // mul  F0 = F2*F4
        put(3, 2, 8, 6, 2);    // sub  F8 = F6-F2
        put(4, 3, 10, 0, 6);   // div  F10 = F0/F6
        put(5, 2, 6, 8, 2);    // add  F6 = F8+F2  (must wait for the divide to read F6)
        // structural use of both multipliers, then a third multiply (R2)
        put(6, 1, 12, 1, 3);
        put(7, 1, 14, 1, 3);
        put(8, 1, 16, 12, 14);
        // output dependence on a pending destination (R3)
        put(9, 2, 12, 1, 1);
        put(10, 0, 20, 0, 0);
        put(11, 0, 21, 0, 0);
        put(12, 2, 22, 20, 21);
        seed = 32'h1234_5678;
        for (int i = 13; i < NPRG; i++) begin
            int k;
            seed = seed * 32'd1103515245 + 32'd12345;
            k = int'((seed >> 16) % 10);
            p_op[i] = (k < 3) ? 0 : (k < 6) ? 2 : (k < 9) ? 1 : 3;
            seed = seed * 32'd1103515245 + 32'd12345;
            p_d[i] = int'((seed >> 16) % 8);
            seed = seed * 32'd1103515245 + 32'd12345;
            p_a[i] = int'((seed >> 16) % 8);
            seed = seed * 32'd1103515245 + 32'd12345;
            p_b[i] = int'((seed >> 16) % 8);
        end
    endtask

    task automatic compare_outputs();
        string t;
        t = e_waw ? "R3" : (freed_last ? "R10" : "R2");
        check(in_ready == e_ready[0], t, "in_ready", int'(in_ready), e_ready);
        if (in_valid && e_ready)
            check(int'(iss_unit) == e_sel, "R2", "iss_unit", int'(iss_unit), e_sel);
        for (int u = 0; u < NU; u++) begin
            t = m_fwd[u] ? "R9" : "R5";
            check(fu_start[u] == e_start[u][0], t, "fu_start", int'(fu_start[u]), e_start[u]);
        end
        t = e_warblk ? "R7" : ((e_nreq > 1) ? "R8" : "R6");
        check(wb_en == e_wb[0], t, "wb_en", int'(wb_en), e_wb);
        if (e_wb) begin
            check(int'(wb_unit) == e_wunit, t, "wb_unit", int'(wb_unit), e_wunit);
            check(int'(wb_reg) == e_wreg, t, "wb_reg", int'(wb_reg), e_wreg);
        end
    endtask

    // watchdog: an expired run counts as a failed check
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d accepted", accepted, NPRG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
        build_program();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, every class accepted
        for (int op = 0; op < 4; op++) begin
            in_op = 2'(op);
            #1;
            check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        end
        check(fu_start == '0, "R1", "fu_start after reset", int'(fu_start), 0);
        check(wb_en == 1'b0, "R1", "wb_en after reset", int'(wb_en), 0);

        while (!(pc >= NPRG && model_idle())) begin
            @(negedge clk);
            if (pc < NPRG) begin
                in_valid = 1'b1;
                in_op    = 2'(p_op[pc]);
                in_dst   = 5'(p_d[pc]);
                in_src1  = 5'(p_a[pc]);
                in_src2  = 5'(p_b[pc]);
            end else begin
                in_valid = 1'b0;
            end
            #1;
            model_eval();
            compare_outputs();
            @(posedge clk);
            model_step();
        end

        // R4: every instruction accepted, one at a time, in order
        check(accepted == NPRG, "R4", "accepted count", accepted, NPRG);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(wb_en == 1'b0, "R10", "idle wb_en", int'(wb_en), 0);
        check(fu_start == '0, "R10", "idle fu_start", int'(fu_start), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule